// File: doc/BRIEF.md
# Host Port Register Bridge

This block sits between a processor's simple parallel I/O lines and the host port of a USB host controller. It drives the controller's two-bit register select, its active-low chip select, read, write and reset lines, and a shared 16-bit data bus. The bridge releases that bus whenever the controller is the one driving it.

On top of the pin layer sits a small sequencer that turns one request into a complete access to the controller's internal memory. The processor raises a request for one clock and supplies a direction, a memory address and, for a store, a data word. The bridge then runs two register cycles on the port. The first writes the memory address into the controller's address register. After a one-clock pause, the second either writes the data word into the data register or reads the data register back. At the end the bridge raises a one-clock done pulse. For a load, the fetched word is already on the read-data output at that point.

Every register cycle has three phases of equal length. In the setup phase the select and chip select are settled. In the strobe phase the read or write strobe is low. In the hold phase the strobe is released but the select and chip select stay put. The phase length is a parameter.

Top module: `hpi_bridge`

## Requirements
- R1: While `rst_n` is low, `hpi_cs_n`, `hpi_rd_n` and `hpi_wr_n` are high, `hpi_rst_n` is low, `done` is low and `rd_data` is zero.
- R2: Register select encoding is data = 0, mailbox = 1, address = 2, status = 3. The first register cycle of every access selects 2 and drives `mem_addr` on `hpi_data` for its whole duration.
- R3: The second register cycle selects 0. On a store (`rd_req` = 0) it drives `wr_data` on `hpi_data` for its whole duration. On a load it pulses `hpi_rd_n` instead of `hpi_wr_n`.
- R4: Each register cycle holds `hpi_cs_n` low for 3×PHASE_CLKS clocks: PHASE_CLKS clocks of setup with both strobes high, then PHASE_CLKS clocks with exactly one strobe low, then PHASE_CLKS clocks of hold with both strobes high. `hpi_addr` is constant while `hpi_cs_n` is low.
- R5: Between the two register cycles there is exactly one clock with `hpi_cs_n`, `hpi_rd_n` and `hpi_wr_n` all high.
- R6: `done` is high for exactly one clock. That clock is 6×PHASE_CLKS+1 clocks after the clock edge that accepted the request.
- R7: A request raised while an access is running (including its done clock) is ignored: no further register cycle and no further done pulse follow.
- R8: On a load, the bridge leaves `hpi_data` undriven while `hpi_rd_n` is low. The value the controller drives on the last strobe clock appears on `rd_data` by the done clock and stays there until the next load.
- R9: `hpi_rst_n` goes high on the first clock edge after `rst_n` is released and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a memory access (sampled while idle) |
| rd_req | input | 1 | 1 = load from controller memory, 0 = store |
| mem_addr | input | 16 | Controller memory address |
| wr_data | input | 16 | Word to store |
| rd_data | output | 16 | Last word loaded |
| done | output | 1 | One-clock pulse at the end of an access |
| hpi_addr | output | 2 | Register select toward the controller |
| hpi_cs_n | output | 1 | Chip select, active low |
| hpi_rd_n | output | 1 | Read strobe, active low |
| hpi_wr_n | output | 1 | Write strobe, active low |
| hpi_rst_n | output | 1 | Controller reset, active low |
| hpi_data | inout | 16 | Shared bidirectional data bus |

## Verification
The pin outputs are decoded from registered sequencer state. Counting the accept edge as clock 0, pin cycle k of an access is therefore visible in the low half of clock k. The pause falls at k = 3×PHASE_CLKS and done at k = 6×PHASE_CLKS+1. The load word is registered on the final strobe edge, so it is present by the done clock. The bench drives and samples on the falling edge and compares every one of those clocks with a pattern it computes arithmetically from k. It does this across a sweep of walking-one addresses and data words in both directions, with extra requests injected mid-access.

// File: rtl/hpi_pkg.sv
// Shared types for the host port bridge.
// Assumes a two-bit register select on the controller side.
package hpi_pkg;

    // Register select codes seen by the controller.
    typedef enum logic [1:0] {
        REG_DATA    = 2'd0,
        REG_MAILBOX = 2'd1,
        REG_ADDRESS = 2'd2,
        REG_STATUS  = 2'd3
    } hpi_reg_e;

    // Sequencer phases of one memory access.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_GAP    = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

endpackage

// File: rtl/hpi_phase_ctr.sv
// Phase length counter.
// Counts clocks while run is high and flags the final clock of a phase of
// LEN clocks. It clears itself on that clock, or whenever run is low.
// Assumes LEN >= 1.
module hpi_phase_ctr #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] TERM = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == TERM);

    // Advance within a phase; restart at the phase boundary or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hpi_seq.sv
// Access sequencer.
// Walks setup, strobe and hold for the address-register cycle, one pause
// clock, setup, strobe and hold for the data-register cycle, then one done
// clock. A request is accepted only in idle.
// Assumes the phase counter reports the last clock of each timed phase.
module hpi_seq
    import hpi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   rd_req,
    input  logic   last,
    output phase_e ph,
    output logic   step,
    output logic   is_read,
    output logic   run,
    output logic   accept,
    output logic   capture,
    output logic   done
);
    phase_e ph_nxt;

    assign run     = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign accept  = (ph == PH_IDLE) && req;
    assign capture = (ph == PH_STROBE) && last && step && is_read;
    assign done    = (ph == PH_DONE);

    // Next-phase selection.
    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_IDLE:   if (req)  ph_nxt = PH_SETUP;
            PH_SETUP:  if (last) ph_nxt = PH_STROBE;
            PH_STROBE: if (last) ph_nxt = PH_HOLD;
            PH_HOLD:   if (last) ph_nxt = step ? PH_DONE : PH_GAP;
            PH_GAP:    ph_nxt = PH_SETUP;
            PH_DONE:   ph_nxt = PH_IDLE;
            default:   ph_nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    // Which register cycle is running, and the direction of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= 1'b0;
            is_read <= 1'b0;
        end else if (accept) begin
            step    <= 1'b0;
            is_read <= rd_req;
        end else if (ph == PH_GAP) begin
            step    <= 1'b1;
        end
    end
endmodule

// File: rtl/hpi_pins.sv
// Pin decoder and data path.
// Latches the request operands, decodes select, chip select and strobes
// from the sequencer state, chooses the word to drive, registers load data
// and produces the controller reset.
// Assumes sequencer state is registered, so decoded pins are glitch-free.
module hpi_pins
    import hpi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph,
    input  logic          step,
    input  logic          is_read,
    input  logic          accept,
    input  logic          capture,
    input  logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] bus_in,
    output logic [1:0]    sel,
    output logic          cs_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ctl_rst_n,
    output logic          drv_en,
    output logic [DW-1:0] drv_val,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] addr_q;
    logic [DW-1:0] wdat_q;
    logic          active;
    logic          strobe;
    logic          cur_read;

    assign active   = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign strobe   = (ph == PH_STROBE);
    assign cur_read = step && is_read;

    // Pin decode from sequencer state.
    always_comb begin
        sel     = step ? REG_DATA : REG_ADDRESS;
        cs_n    = !active;
        rd_n    = !(strobe && cur_read);
        wr_n    = !(strobe && !cur_read);
        drv_en  = active && !cur_read;
        drv_val = step ? wdat_q : addr_q;
    end

    // Hold the request operands for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            addr_q <= mem_addr;
            wdat_q <= wr_data;
        end
    end

    // Take the loaded word on the last strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= bus_in;
    end

    // Controller reset follows the system reset, released one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_rst_n <= 1'b0;
        else        ctl_rst_n <= 1'b1;
    end
endmodule

// File: rtl/hpi_bridge.sv
// Top of the host port bridge.
// Joins the phase counter, the sequencer and the pin decoder, and owns the
// tri-state driver of the shared data bus.
// Assumes a single-clock request pulse, sampled only while idle.
module hpi_bridge
    import hpi_pkg::*;
#(
    parameter int DW         = 16,
    parameter int PHASE_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          rd_req,
    input  logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [1:0]    hpi_addr,
    output logic          hpi_cs_n,
    output logic          hpi_rd_n,
    output logic          hpi_wr_n,
    output logic          hpi_rst_n,
    inout  wire  [DW-1:0] hpi_data
);
    phase_e        ph;
    logic          step;
    logic          is_read;
    logic          run;
    logic          last;
    logic          accept;
    logic          capture;
    logic          drv_en;
    logic [DW-1:0] drv_val;

    hpi_phase_ctr #(.LEN(PHASE_CLKS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .last  (last)
    );

    hpi_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .rd_req  (rd_req),
        .last    (last),
        .ph      (ph),
        .step    (step),
        .is_read (is_read),
        .run     (run),
        .accept  (accept),
        .capture (capture),
        .done    (done)
    );

    hpi_pins #(.DW(DW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .step      (step),
        .is_read   (is_read),
        .accept    (accept),
        .capture   (capture),
        .mem_addr  (mem_addr),
        .wr_data   (wr_data),
        .bus_in    (hpi_data),
        .sel       (hpi_addr),
        .cs_n      (hpi_cs_n),
        .rd_n      (hpi_rd_n),
        .wr_n      (hpi_wr_n),
        .ctl_rst_n (hpi_rst_n),
        .drv_en    (drv_en),
        .drv_val   (drv_val),
        .rd_data   (rd_data)
    );

    // Drive the shared bus only when the bridge owns it.
    assign hpi_data = drv_en ? drv_val : {DW{1'bz}};
endmodule

// File: rtl/hpi_bridge_chk.sv
// Protocol checker for the host port bridge, bound to the top module.
// Watches only the pins and done. One counter measures strobe length.
module hpi_bridge_chk #(
    parameter int PHASE_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] hpi_addr,
    input logic       hpi_cs_n,
    input logic       hpi_rd_n,
    input logic       hpi_wr_n
);
    logic        strb_low;
    logic [15:0] strb_cnt;

    assign strb_low = !hpi_rd_n || !hpi_wr_n;

    // Count consecutive clocks with a strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)        strb_cnt <= '0;
        else if (strb_low) strb_cnt <= strb_cnt + 1'b1;
        else               strb_cnt <= '0;
    end

    // R4
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_low |-> !hpi_cs_n);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hpi_rd_n && !hpi_wr_n));

    // R4
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hpi_cs_n && $past(!hpi_cs_n)) |-> $stable(hpi_addr));

    // R4
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hpi_rd_n) || $fell(hpi_wr_n)) |-> $past(!hpi_cs_n));

    // R4
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hpi_cs_n) |-> $past(hpi_rd_n && hpi_wr_n));

    // R4
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hpi_rd_n) || $rose(hpi_wr_n)) |-> (strb_cnt == 16'(PHASE_CLKS)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hpi_cs_n && hpi_rd_n && hpi_wr_n));
endmodule

bind hpi_bridge hpi_bridge_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .hpi_addr (hpi_addr),
    .hpi_cs_n (hpi_cs_n),
    .hpi_rd_n (hpi_rd_n),
    .hpi_wr_n (hpi_wr_n)
);

// File: tb/sim_hpi_bridge.sv
// Bench for the host port bridge: a swept set of loads and stores, every
// pin clock compared with an arithmetically computed pattern.
module sim_hpi_bridge;
    localparam int PH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done;
    logic [1:0]  hpi_addr;
    logic        hpi_cs_n, hpi_rd_n, hpi_wr_n, hpi_rst_n;
    wire  [15:0] hpi_data;
    logic [15:0] ctrl_val = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Controller model: drives the bus only while it is being read.
    assign hpi_data = (!hpi_cs_n && !hpi_rd_n) ? ctrl_val : 16'bz;

    hpi_bridge #(.DW(16), .PHASE_CLKS(PH)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_req(rd_req),
        .mem_addr(mem_addr), .wr_data(wr_data), .rd_data(rd_data),
        .done(done), .hpi_addr(hpi_addr), .hpi_cs_n(hpi_cs_n),
        .hpi_rd_n(hpi_rd_n), .hpi_wr_n(hpi_wr_n), .hpi_rst_n(hpi_rst_n),
        .hpi_data(hpi_data)
    );

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    // One access; the returned pins are compared clock by clock.
    task automatic access(input bit rd, input logic [15:0] a, input logic [15:0] d, input bit poke);
        int e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0;
        logic [31:0] a2 = 0, a4 = 0;
        ctrl_val = d;
        @(negedge clk);
        mem_addr = a; wr_data = rd ? 16'h0 : d; rd_req = rd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k <= 6*PH; k++) begin
            bit st = 0, gap = 0, strb, rop, drv;
            int pos = 0;
            logic [1:0] ea;
            logic [15:0] ev;
            if (k < 3*PH) pos = k;
            else if (k == 3*PH) gap = 1;
            else begin st = 1; pos = k - 3*PH - 1; end
            strb = !gap && pos >= PH && pos < 2*PH;
            rop  = st && rd;
            drv  = !gap && !rop;
            ea   = st ? 2'd0 : 2'd2;
            ev   = st ? d : a;
            if (gap) begin
                if (!(hpi_cs_n && hpi_rd_n && hpi_wr_n)) e5++;
            end else begin
                if (hpi_cs_n !== 1'b0 || hpi_rd_n !== !(strb && rop) || hpi_wr_n !== !(strb && !rop)) begin
                    e4++; a4 = {k[15:0], 13'd0, hpi_cs_n, hpi_rd_n, hpi_wr_n};
                end
                if (hpi_addr !== ea || (drv && hpi_data !== ev)) begin
                    if (st) e3++; else e2++;
                    a2 = {14'd0, hpi_addr, hpi_data};
                end
            end
            if (done) e6++;
            if (poke && (k == 2 || k == 5 || k == 9)) begin
                mem_addr = ~a; rd_req = !rd; req = 1'b1;
            end
            @(negedge clk);
            req = 1'b0;
        end
        check(e2 == 0, "R2 address-register cycle", a2, {14'd0, 2'd2, a});
        check(e3 == 0, "R3 data-register cycle", a2, {14'd0, 2'd0, d});
        check(e4 == 0, "R4 phase timing", a4, 32'd0);
        check(e5 == 0, "R5 pause clock", 32'(e5), 32'd0);
        check(e6 == 0 && done === 1'b1, "R6 done due at k=6*PH+1", {31'd0, done}, 32'd1);
        if (poke) req = 1'b1;
        if (rd) check(rd_data === d, "R8 load word", {16'd0, rd_data}, {16'd0, d});
        @(negedge clk);
        req = 1'b0;
        check(done === 1'b0, "R6 done single clock", {31'd0, done}, 32'd0);
        if (poke) begin
            int seen = 0;
            for (int k = 0; k < 4*PH + 4; k++) begin
                if (!hpi_cs_n || done) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R7 request while busy ignored", 32'(seen), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(hpi_cs_n === 1'b1 && hpi_rd_n === 1'b1 && hpi_wr_n === 1'b1, "R1 strobes idle in reset",
              {29'd0, hpi_cs_n, hpi_rd_n, hpi_wr_n}, 32'd7);
        check(hpi_rst_n === 1'b0, "R1 controller held in reset", {31'd0, hpi_rst_n}, 32'd0);
        check(done === 1'b0 && rd_data === 16'd0, "R1 outputs cleared", {15'd0, done, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hpi_rst_n === 1'b1, "R9 controller reset released", {31'd0, hpi_rst_n}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w = 16'(1) << i;
            access(1'b0, w, ~w, 1'b0);
            access(1'b1, w ^ 16'hA5A5, w ^ 16'h3C3C, (i % 4) == 1);
        end
        access(1'b0, 16'hFFFF, 16'h0000, 1'b1);
        access(1'b1, 16'h0000, 16'hFFFF, 1'b0);
        access(1'b0, 16'h1234, 16'h5678, 1'b0);
        check(rd_data === 16'hFFFF, "R8 load word kept after store", {16'd0, rd_data}, 32'hFFFF);
        check(hpi_rst_n === 1'b1, "R9 controller reset stays high", {31'd0, hpi_rst_n}, 32'd1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule